// File: doc/BRIEF.md
# Embedded Operation Toggle Status Generator

This block sits on the read path of a banked memory device and tells the host whether an internal program or erase job is still running. Once the sequencer accepts the final write strobe of a command, the bank that owns the job enters status mode. A read to that bank then returns status on data bit 6 instead of array data. The status bit flips on every such read, so two reads in a row that differ mean "still busy". When the job finishes, reads to that bank return normal array data again.

The toggle advances once per read access that hits the busy bank. It does not advance once per clock. Reads to other banks pass array data through and leave the toggle alone.

An erase request can arrive with every selected sector protected. In that case there is no real job to run. The block still reports a busy status for a fixed, parameterised number of clock cycles, and then it returns to array data by itself.

Top module: `status_toggle_gen`

## Requirements
- R1: After reset the block is idle: `status_o` is 0 and `dq6_o` equals `arr_d6_i` for any read.
- R2: A command strobe (`arm_i` = 1) accepted while idle captures `arm_bank_i`. From the next cycle, reads to that bank are status reads (`status_o` = 1), and the first of them returns 0 on `dq6_o`.
- R3: During status mode, every status read returns the current toggle bit. The following status read returns its inverse.
- R4: A read whose `rd_bank_i` differs from the captured bank returns `arr_d6_i` with `status_o` = 0, and the next status read is unaffected.
- R5: Clock cycles that carry no status read leave the toggle bit unchanged.
- R6: In normal busy mode, an `op_done_i` pulse ends status mode from the next cycle. Reads then return array data.
- R7: If `arm_i` arrives with `erase_i` = 1 and `all_prot_i` = 1, status mode lasts exactly `PROT_CYCLES` cycles and then ends without any `op_done_i`. Any `op_done_i` during that window is ignored.
- R8: A command strobe that arrives while status mode is active is ignored. The captured bank and the toggle bit stay as they were.
- R9: Each newly accepted operation restarts the toggle bit at 0, whatever value the previous operation left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse: final write strobe of a program/erase command accepted |
| erase_i | input | 1 | Qualifies `arm_i`: the command is an erase |
| all_prot_i | input | 1 | Qualifies `arm_i`: every sector selected for erase is protected |
| arm_bank_i | input | BANK_W | Bank addressed by the command |
| op_done_i | input | 1 | Pulse from the sequencer: embedded operation finished |
| rd_i | input | 1 | Read access strobe, one per read cycle |
| rd_bank_i | input | BANK_W | Bank addressed by the read |
| arr_d6_i | input | 1 | Bit 6 of the array data for the read |
| dq6_o | output | 1 | Bit 6 returned to the host |
| status_o | output | 1 | High when `dq6_o` carries status rather than array data |

## Verification
The hardest case to reach from the ports is the protected-erase window. Its end is set only by an internal count, and no port signals it. The stimulus starts such an erase and reads the busy bank at uneven spacing across the whole window, including reads in the last counted cycle and the first cycle after it. It also injects an `op_done_i` pulse and a second command strobe partway through. The reference model in the bench counts the same window independently, so a window that is one cycle short or long shows up as a mismatch on the read at the boundary.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_BUSY = 2'd1,
        TS_PROT = 2'd2
    } tgl_mode_e;

    typedef struct packed {
        logic arm;
        logic erase;
        logic all_prot;
        logic done;
    } tgl_cmd_t;

    function automatic logic mode_active(input tgl_mode_e m);
        return (m != TS_IDLE);
    endfunction

    function automatic tgl_mode_e entry_mode(input tgl_cmd_t c);
        return (c.erase && c.all_prot) ? TS_PROT : TS_BUSY;
    endfunction

endpackage

// File: rtl/tgl_ctrl.sv
module tgl_ctrl
    import tgl_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  tgl_cmd_t          cmd,
    input  logic [BANK_W-1:0] arm_bank,
    input  logic              expired,
    output tgl_mode_e         mode_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              start
);
    tgl_mode_e mode_d;

    assign start = (mode_q == TS_IDLE) && cmd.arm;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            TS_IDLE: if (cmd.arm)  mode_d = entry_mode(cmd);
            TS_BUSY: if (cmd.done) mode_d = TS_IDLE;
            TS_PROT: if (expired)  mode_d = TS_IDLE;
            default: mode_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TS_IDLE;
            bank_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (start) bank_q <= arm_bank;
        end
    end
endmodule

// File: rtl/tgl_timer.sv
module tgl_timer #(
    parameter int PROT_CYCLES = 1000,
    localparam int CNT_W = $clog2(PROT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic             expired,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROT_CYCLES - 1);

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tgl_bit.sv
module tgl_bit (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic tgl_q
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            tgl_q <= 1'b0;
        else if (advance)
            tgl_q <= ~tgl_q;
    end
endmodule

// File: rtl/status_toggle_gen.sv
module status_toggle_gen
    import tgl_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int PROT_CYCLES = 1000,
    localparam int CNT_W = $clog2(PROT_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              erase_i,
    input  logic              all_prot_i,
    input  logic [BANK_W-1:0] arm_bank_i,
    input  logic              op_done_i,
    input  logic              rd_i,
    input  logic [BANK_W-1:0] rd_bank_i,
    input  logic              arr_d6_i,
    output logic              dq6_o,
    output logic              status_o
);
    tgl_cmd_t          cmd;
    tgl_mode_e         mode_q;
    logic [BANK_W-1:0] bank_q;
    logic              start;
    logic              expired;
    logic [CNT_W-1:0]  cnt_q;
    logic              tgl_q;
    logic              hit;

    assign cmd = '{arm: arm_i, erase: erase_i, all_prot: all_prot_i, done: op_done_i};

    tgl_ctrl #(.BANK_W(BANK_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .arm_bank(arm_bank_i),
        .expired(expired), .mode_q(mode_q), .bank_q(bank_q), .start(start)
    );

    tgl_timer #(.PROT_CYCLES(PROT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .clear(start), .run(mode_q == TS_PROT),
        .expired(expired), .cnt_q(cnt_q)
    );

    assign hit = mode_active(mode_q) && rd_i && (rd_bank_i == bank_q);

    tgl_bit u_bit (
        .clk(clk), .rst(rst), .clear(start), .advance(hit), .tgl_q(tgl_q)
    );

    assign status_o = hit;
    assign dq6_o    = hit ? tgl_q : arr_d6_i;
endmodule

// File: rtl/status_toggle_gen_chk.sv
module status_toggle_gen_chk
    import tgl_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int PROT_CYCLES = 1000,
    localparam int CNT_W = $clog2(PROT_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              op_done_i,
    input logic              rd_i,
    input logic [BANK_W-1:0] rd_bank_i,
    input logic              status_o,
    input tgl_mode_e         mode_q,
    input logic [BANK_W-1:0] bank_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              tgl_q
);
    assert_arm_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TS_IDLE && arm_i) |=> (mode_q != TS_IDLE && tgl_q == 1'b0));

    assert_read_flips_R3: assert property (@(posedge clk) disable iff (rst)
        (status_o && !(mode_q == TS_IDLE && arm_i)) |=> (tgl_q != $past(tgl_q)));

    assert_no_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!status_o && !(mode_q == TS_IDLE && arm_i)) |=> $stable(tgl_q));

    assert_other_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_bank_i != bank_q) |-> !status_o);

    assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TS_BUSY && op_done_i) |=> (mode_q == TS_IDLE));

    assert_window_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TS_PROT) |-> (cnt_q <= CNT_W'(PROT_CYCLES - 1)));

    assert_arm_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q != TS_IDLE && arm_i) |=> $stable(bank_q));
endmodule

bind status_toggle_gen status_toggle_gen_chk #(
    .BANK_W(BANK_W), .PROT_CYCLES(PROT_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .arm_i(arm_i), .op_done_i(op_done_i),
    .rd_i(rd_i), .rd_bank_i(rd_bank_i), .status_o(status_o),
    .mode_q(mode_q), .bank_q(bank_q), .cnt_q(cnt_q), .tgl_q(tgl_q)
);

// File: tb/status_toggle_gen_bench.sv
module status_toggle_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W     = 2;
    localparam int PROT       = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 0, ers = 0, prot = 0, done = 0, rd = 0, ad = 0;
    logic [BANK_W-1:0] abank = '0, rbank = '0;
    logic dq6, st;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 busy, 2 timed protected window
    int m_mode = 0, m_tgl = 0, m_bank = 0, m_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_toggle_gen #(.BANK_W(BANK_W), .PROT_CYCLES(PROT)) u_status_toggle_gen (
        .clk(clk), .rst(rst), .arm_i(arm), .erase_i(ers), .all_prot_i(prot),
        .arm_bank_i(abank), .op_done_i(done), .rd_i(rd), .rd_bank_i(rbank),
        .arr_d6_i(ad), .dq6_o(dq6), .status_o(st)
    );

    always @(posedge clk) begin
        bit hit;
        cycles++;
        hit = (m_mode != 0) && rd && (int'(rbank) == m_bank);
        if (rst) begin
            m_mode = 0; m_tgl = 0; m_bank = 0; m_left = 0;
        end else if (m_mode == 0) begin
            if (arm) begin
                m_bank = int'(abank);
                m_tgl  = 0;
                if (ers && prot) begin m_mode = 2; m_left = PROT; end
                else m_mode = 1;
            end
        end else begin
            if (hit) m_tgl = 1 - m_tgl;
            if (m_mode == 1 && done) m_mode = 0;
            if (m_mode == 2) begin
                m_left--;
                if (m_left == 0) m_mode = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // drive one cycle of inputs (called at a falling edge), compare outputs, advance
    task automatic step(input string tag, input logic a, input logic e, input logic p,
                        input logic d, input logic r, input int rb, input logic arr,
                        input int ab = 0);
        bit hit;
        arm = a; ers = e; prot = p; done = d; rd = r; ad = arr;
        rbank = BANK_W'(rb); abank = BANK_W'(ab);
        #1;
        hit = (m_mode != 0) && r && (rb == m_bank);
        chk({tag, " status"}, int'(st), int'(hit));
        chk({tag, " dq6"}, int'(dq6), hit ? m_tgl : int'(arr));
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, array passes through
        step("R1", 0, 0, 0, 0, 1, 0, 1);
        step("R1", 0, 0, 0, 0, 1, 1, 0);
        chk("R1 idle status", int'(st), 0);

        // R2: program command on bank 1; read in the arm cycle is still array data
        step("R2", 1, 0, 0, 0, 1, 1, 1, 1);
        rd = 1; rbank = 2'd1; ad = 1'b1; arm = 0; #1;
        chk("R2 first status read", int'(dq6), 0);
        chk("R2 status flag", int'(st), 1);
        @(negedge clk);
        // R3: successive reads alternate
        for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 0, 1, 1, 1);
        // R5: gaps without reads do not advance
        idle("R5", 3);
        step("R5", 0, 0, 0, 0, 1, 1, 0);
        // R4: other-bank reads pass array data
        step("R4", 0, 0, 0, 0, 1, 2, 1);
        step("R4", 0, 0, 0, 0, 1, 0, 0);
        step("R4", 0, 0, 0, 0, 1, 1, 1);
        // R8: a new command while busy is ignored
        step("R8", 1, 1, 1, 0, 0, 0, 0, 3);
        step("R8", 0, 0, 0, 0, 1, 3, 1);
        step("R8", 0, 0, 0, 0, 1, 1, 0);
        // R6: completion ends status mode
        step("R6", 0, 0, 0, 1, 1, 1, 0);
        step("R6", 0, 0, 0, 0, 1, 1, 1);
        rd = 1; rbank = 2'd1; ad = 1'b0; #1;
        chk("R6 array after done", int'(dq6), 0);
        chk("R6 flag after done", int'(st), 0);
        @(negedge clk);

        // R9: leave toggle at 1, finish, rearm -> first read 0
        step("R9", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 0, 1);
        step("R9", 0, 0, 0, 1, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0);
        rd = 1; rbank = 2'd0; ad = 1'b1; arm = 0; #1;
        chk("R9 restart at zero", int'(dq6), 0);
        @(negedge clk);
        step("R9", 0, 0, 0, 1, 0, 0, 0);

        // R7: erase with all sectors protected on bank 2
        step("R7", 1, 1, 1, 0, 0, 0, 0, 2);
        for (int i = 0; i < PROT; i++) begin
            logic r;
            r = (i % 3 == 0) || (i >= PROT - 2);
            step("R7", (i == 20), 0, 0, (i == 10), r, 2, 1, 1);
        end
        rd = 1; rbank = 2'd2; ad = 1'b1; #1;
        chk("R7 window closed flag", int'(st), 0);
        chk("R7 window closed data", int'(dq6), 1);
        @(negedge clk);
        idle("R7", 2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog t=%0t actual=hung expected=done", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule